// File: doc/BRIEF.md
# Spread-Spectrum Triangular Profile Generator

This block produces the frequency-offset word that a fractional-N feedback divider adds to its nominal ratio so that the synthesized clock sweeps slowly around its target and its spectral energy spreads out. The sweep is a linear triangle. One triangle lasts a programmable number of reference-clock ticks. The offset moves by a constant slope of peak swing divided by half the period. Exact integer division keeps the result free of drift: at phase position j of a half period H, the magnitude is floor(P*j/H).

Two spread shapes are offered. In center spread the offset swings symmetrically about zero. In down spread it moves only between zero and a negative peak, so the resulting frequency never exceeds nominal. A deviation code sets the swing. The period count sets the modulation rate. A combinational checker flags a period shorter than the allowed reference-to-modulation ratio, and also a deviation code outside the range of the selected shape. New settings are captured only when a triangle begins, so a setting change never breaks a ramp in the middle. All divider outputs take the same offset word.

Top module: `ssc_triangle_gen`

## Requirements
- R1: `cfg_err_o` is 1 in the same cycle when `period_i` is below 225, or when `dev_code_i` is out of range for the selected shape (center `mode_i`=0: 1..24; down `mode_i`=1: 1..16). Otherwise it is 0.
- R2: At any clock edge where `en_i` is 0, the generator goes idle. `offset_o` then reads exactly 0 from that edge on. After re-enable, the first tick starts a new triangle at phase 0 and does not resume the old one.
- R3: `offset_o` changes only at clock edges where `tick_i` is 1 (or where `en_i` is 0). On other edges it holds its value.
- R4: A triangle lasts 2*floor(`period_i`/2) ticks. The tick that starts it gives phase k=0, and each later tick advances k by 1.
- R5: In center spread with code c (one offset LSB = 1/64 of 0.125 %), the offset at phase k is c*64 - floor(128*c*j/H), where H = floor(period/2) and j = k for k<=H, else 2H-k. It peaks at +c*64 at k=0 and at -c*64 at k=H.
- R6: In down spread with code d, the offset at phase k is -floor(128*d*j/H), with H and j defined as in R5. It is 0 at k=0, reaches -128*d at k=H, and is never positive.
- R7: Changes to `mode_i`, `dev_code_i` or `period_i` take effect only at the tick that starts the next triangle. Until then the running triangle completes with its captured settings.
- R8: If the settings are invalid (R1) at a tick that would start a triangle, the generator stays idle and `offset_o` reads 0. It starts at the first tick that sees valid settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One reference-cycle step qualifier |
| en_i | input | 1 | Spread enable |
| mode_i | input | 1 | Shape: 0 center, 1 down |
| dev_code_i | input | 5 | Deviation code |
| period_i | input | 16 | Reference ticks per modulation period |
| offset_o | output | 16 | Signed offset word, two's complement |
| cfg_err_o | output | 1 | Settings violate ratio or code range |

## Verification
`cfg_err_o` is combinational. The bench drives the settings on a falling edge and checks the flag a nanosecond later, sweeping every code in both shapes against periods on each side of 225. `offset_o` comes from registers that update on the rising edge where `tick_i` is high. The bench raises the tick on a falling edge and reads the word at the following falling edge. It then lets one untick'd edge pass and reads again to confirm the value holds. Every expected value is taken from the closed-form triangle in R5 and R6 at the phase number the bench counts itself.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic {
    SPREAD_CENTER = 1'b0,
    SPREAD_DOWN   = 1'b1
  } spread_e;
endpackage

// File: rtl/ssc_cfg_check.sv
module ssc_cfg_check
  import ssc_pkg::*;
#(
  parameter int PER_W     = 16,
  parameter int CODE_W    = 5,
  parameter int AMP_W     = 12,
  parameter int MIN_RATIO = 225,
  parameter int CTR_MAX   = 24,
  parameter int DN_MAX    = 16,
  parameter int STEP_LSB  = 64
) (
  input  logic              mode_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [PER_W-1:0]  period_i,
  output logic              valid_o,
  output logic [AMP_W-1:0]  swing_o,
  output logic [AMP_W-1:0]  base_o,
  output logic [PER_W-2:0]  half_o
);
  logic             code_ok, per_ok;
  logic [AMP_W-1:0] amp;

  always_comb begin
    if (spread_e'(mode_i) == SPREAD_CENTER)
      code_ok = (code_i != '0) && (code_i <= CODE_W'(CTR_MAX));
    else
      code_ok = (code_i != '0) && (code_i <= CODE_W'(DN_MAX));
    per_ok  = period_i >= PER_W'(MIN_RATIO);
    valid_o = code_ok && per_ok;
    amp     = AMP_W'(code_i) * AMP_W'(STEP_LSB);
    swing_o = amp << 1;
    base_o  = (spread_e'(mode_i) == SPREAD_CENTER) ? amp : '0;
    half_o  = period_i[PER_W-1:1];
  end
endmodule

// File: rtl/ssc_slope_div.sv
module ssc_slope_div #(
  parameter int AMP_W  = 12,
  parameter int HALF_W = 15
) (
  input  logic [AMP_W-1:0]  swing_i,
  input  logic [HALF_W-1:0] half_i,
  output logic [AMP_W-1:0]  quot_o,
  output logic [HALF_W-1:0] rem_o
);
  localparam int DW = (AMP_W > HALF_W) ? AMP_W : HALF_W;
  logic [DW-1:0] num, den, q, r;

  always_comb begin
    num = DW'(swing_i);
    den = DW'(half_i);
    if (den == '0) begin
      q = '0;
      r = '0;
    end else begin
      q = num / den;
      r = num % den;
    end
    quot_o = q[AMP_W-1:0];
    rem_o  = r[HALF_W-1:0];
  end
endmodule

// File: rtl/ssc_tri_core.sv
module ssc_tri_core #(
  parameter int PER_W = 16,
  parameter int AMP_W = 12,
  parameter int OFS_W = 16,
  localparam int HALF_W = PER_W - 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic                    en_i,
  input  logic                    valid_i,
  input  logic [AMP_W-1:0]        base_i,
  input  logic [HALF_W-1:0]       half_i,
  input  logic [AMP_W-1:0]        quot_i,
  input  logic [HALF_W-1:0]       rem_i,
  output logic                    run_o,
  output logic signed [OFS_W-1:0] offset_o
);
  logic              run_q;
  logic [PER_W-1:0]  k_q;
  logic [AMP_W-1:0]  m_q, base_q, quot_q;
  logic [HALF_W-1:0] r_q, half_q, rem_q;

  logic              last, ascend, wrap_up, borrow;
  logic [HALF_W:0]   sum_up;
  logic [HALF_W-1:0] r_up, r_dn;
  logic [AMP_W-1:0]  m_up, m_dn;

  always_comb begin
    last    = k_q == ({half_q, 1'b0} - PER_W'(1));
    ascend  = k_q < {1'b0, half_q};
    // exact floor(P*j/H): m*H + r tracks P*j
    sum_up  = {1'b0, r_q} + {1'b0, rem_q};
    wrap_up = sum_up >= {1'b0, half_q};
    r_up    = wrap_up ? HALF_W'(sum_up - {1'b0, half_q}) : sum_up[HALF_W-1:0];
    m_up    = m_q + quot_q + AMP_W'(wrap_up);
    borrow  = r_q < rem_q;
    r_dn    = borrow ? (r_q + half_q - rem_q) : (r_q - rem_q);
    m_dn    = m_q - quot_q - AMP_W'(borrow);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      k_q    <= '0;
      m_q    <= '0;
      r_q    <= '0;
      base_q <= '0;
      half_q <= '0;
      quot_q <= '0;
      rem_q  <= '0;
    end else if (!en_i) begin
      run_q <= 1'b0;
      k_q   <= '0;
      m_q   <= '0;
      r_q   <= '0;
    end else if (tick_i) begin
      if (!run_q || last) begin
        run_q <= valid_i;
        k_q   <= '0;
        m_q   <= '0;
        r_q   <= '0;
        if (valid_i) begin
          base_q <= base_i;
          half_q <= half_i;
          quot_q <= quot_i;
          rem_q  <= rem_i;
        end
      end else begin
        k_q <= k_q + PER_W'(1);
        if (ascend) begin
          m_q <= m_up;
          r_q <= r_up;
        end else begin
          m_q <= m_dn;
          r_q <= r_dn;
        end
      end
    end
  end

  assign run_o    = run_q;
  assign offset_o = run_q ? ($signed(OFS_W'(base_q)) - $signed(OFS_W'(m_q))) : '0;
endmodule

// File: rtl/ssc_triangle_gen.sv
module ssc_triangle_gen #(
  parameter int PER_W     = 16,
  parameter int CODE_W    = 5,
  parameter int OFS_W     = 16,
  parameter int MIN_RATIO = 225,
  parameter int CTR_MAX   = 24,
  parameter int DN_MAX    = 16,
  parameter int STEP_LSB  = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic                    en_i,
  input  logic                    mode_i,
  input  logic [CODE_W-1:0]       dev_code_i,
  input  logic [PER_W-1:0]        period_i,
  output logic signed [OFS_W-1:0] offset_o,
  output logic                    cfg_err_o
);
  localparam int CODE_TOP = (1 << CODE_W) - 1;
  localparam int AMP_W    = $clog2(2 * CODE_TOP * STEP_LSB + 1);
  localparam int HALF_W   = PER_W - 1;

  logic              cfg_valid, run_q;
  logic [AMP_W-1:0]  swing, base, quot;
  logic [HALF_W-1:0] half, rem;

  ssc_cfg_check #(
    .PER_W(PER_W), .CODE_W(CODE_W), .AMP_W(AMP_W), .MIN_RATIO(MIN_RATIO),
    .CTR_MAX(CTR_MAX), .DN_MAX(DN_MAX), .STEP_LSB(STEP_LSB)
  ) u_cfg (
    .mode_i   (mode_i),
    .code_i   (dev_code_i),
    .period_i (period_i),
    .valid_o  (cfg_valid),
    .swing_o  (swing),
    .base_o   (base),
    .half_o   (half)
  );

  ssc_slope_div #(.AMP_W(AMP_W), .HALF_W(HALF_W)) u_div (
    .swing_i (swing),
    .half_i  (half),
    .quot_o  (quot),
    .rem_o   (rem)
  );

  ssc_tri_core #(.PER_W(PER_W), .AMP_W(AMP_W), .OFS_W(OFS_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .en_i     (en_i),
    .valid_i  (cfg_valid),
    .base_i   (base),
    .half_i   (half),
    .quot_i   (quot),
    .rem_i    (rem),
    .run_o    (run_q),
    .offset_o (offset_o)
  );

  assign cfg_err_o = !cfg_valid;
endmodule

// File: rtl/ssc_triangle_gen_chk.sv
module ssc_triangle_gen_chk #(
  parameter int OFS_W = 16,
  parameter int HI    = 1536,
  parameter int LO    = -2048
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    tick_i,
  input logic                    en_i,
  input logic                    cfg_err_o,
  input logic                    run_q,
  input logic signed [OFS_W-1:0] offset_o
);
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> offset_o == '0); // R2

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(offset_o)); // R3

  AST_OFS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(offset_o) <= HI) && (int'(offset_o) >= LO)); // R6

  AST_BAD_CFG_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cfg_err_o && !run_q) |=> offset_o == '0); // R8

  AST_START_ON_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> $past(tick_i && en_i && !cfg_err_o)); // R8
endmodule

bind ssc_triangle_gen ssc_triangle_gen_chk #(
  .OFS_W (OFS_W),
  .HI    (CTR_MAX * STEP_LSB),
  .LO    (-2 * DN_MAX * STEP_LSB)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .en_i      (en_i),
  .cfg_err_o (cfg_err_o),
  .run_q     (run_q),
  .offset_o  (offset_o)
);

// File: tb/ssc_triangle_gen_tb.sv
module ssc_triangle_gen_tb;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               tick = 1'b0;
  logic               en = 1'b0;
  logic               mode = 1'b0;
  logic [4:0]         code = '0;
  logic [15:0]        period = '0;
  logic signed [15:0] offset;
  logic               cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  ssc_triangle_gen u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tick_i     (tick),
    .en_i       (en),
    .mode_i     (mode),
    .dev_code_i (code),
    .period_i   (period),
    .offset_o   (offset),
    .cfg_err_o  (cfg_err)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_val(int m, int c, int per, int k);
    int p = 2 * c * 64;
    int h = per / 2;
    int j = (k <= h) ? k : 2 * h - k;
    int b = (m == 0) ? c * 64 : 0;
    return b - (p * j) / h;
  endfunction

  // caller sits just after a falling edge
  task automatic tick_sample(output int v, input string tag);
    tick = 1'b1;
    @(posedge clk); @(negedge clk);
    tick = 1'b0;
    v = int'(offset);
    @(posedge clk); @(negedge clk);
    chk({tag, " R3 hold"}, int'(offset), v);
  endtask

  task automatic restart(input int m, input int c, input int per);
    en = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R2 idle after disable", int'(offset), 0);
    mode = m[0]; code = c[4:0]; period = per[15:0]; en = 1'b1;
  endtask

  task automatic run_seq(input int m, input int c, input int per, input int n);
    int v;
    int len = 2 * (per / 2);
    restart(m, c, per);
    for (int t = 0; t < n; t++) begin
      tick_sample(v, (m == 0) ? "R5" : "R6");
      chk((m == 0) ? "R5/R4 center value" : "R6/R4 down value", v,
          exp_val(m, c, per, t % len));
      if (m == 1 && v > 0) chk("R6 never positive", v, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 reset offset", int'(offset), 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);

    // R1: every code, both shapes, periods around the limit
    for (int m = 0; m < 2; m++)
      for (int pi = 0; pi < 4; pi++)
        for (int c = 0; c < 32; c++) begin
          int per = (pi == 0) ? 0 : (pi == 1) ? 224 : (pi == 2) ? 225 : 4000;
          int lim = (m == 0) ? 24 : 16;
          mode = m[0]; code = c[4:0]; period = per[15:0];
          #1;
          chk("R1 cfg_err", int'(cfg_err),
              ((per < 225) || (c < 1) || (c > lim)) ? 1 : 0);
          @(negedge clk);
        end

    // R4/R5/R6: full triangles, both shapes, odd and even periods
    run_seq(0, 1, 225, 2 * 224 + 3);
    run_seq(0, 24, 226, 226 + 5);
    run_seq(0, 7, 301, 300 + 2);
    run_seq(1, 1, 225, 224 + 3);
    run_seq(1, 16, 400, 400 + 2);
    run_seq(1, 5, 257, 256 + 2);

    // R7: change mid-triangle, takes effect at next start
    restart(0, 4, 240);
    for (int t = 0; t < 240 + 305; t++) begin
      if (t == 60) begin mode = 1'b1; code = 5'd3; period = 16'd300; end
      tick_sample(v, "R7");
      if (t < 240) chk("R7 old settings kept", v, exp_val(0, 4, 240, t));
      else         chk("R7 new settings used", v, exp_val(1, 3, 300, (t - 240) % 300));
    end

    // R8: settings turn invalid mid-triangle
    restart(0, 10, 226);
    for (int t = 0; t < 226; t++) begin
      if (t == 10) period = 16'd100;
      tick_sample(v, "R8");
      chk("R8 running triangle completes", v, exp_val(0, 10, 226, t));
    end
    for (int t = 0; t < 4; t++) begin
      tick_sample(v, "R8");
      chk("R8 idle on invalid settings", v, 0);
    end
    code = 5'd0; period = 16'd226;
    tick_sample(v, "R8");
    chk("R8 idle on bad code", v, 0);
    code = 5'd10;
    for (int t = 0; t < 5; t++) begin
      tick_sample(v, "R8");
      chk("R8 start on valid", v, exp_val(0, 10, 226, t));
    end

    // R2: disable mid-triangle, then restart from phase 0
    restart(1, 8, 230);
    for (int t = 0; t < 50; t++) tick_sample(v, "R2");
    chk("R2 mid value", v, exp_val(1, 8, 230, 49));
    en = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R2 zero after disable", int'(offset), 0);
    for (int t = 0; t < 3; t++) begin
      tick_sample(v, "R2");
      chk("R2 zero while disabled", v, 0);
    end
    en = 1'b1;
    for (int t = 0; t < 4; t++) begin
      tick_sample(v, "R2");
      chk("R2 restart at phase 0", v, exp_val(1, 8, 230, t));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule